// File: doc/BRIEF.md
# Clock Buffer Enable Arbiter

This block holds the software on/off state of four clock buffers and serves requests that change one of them. Each request carries a buffer index and the desired value. The block refuses the request if the index is out of range or if that buffer is configured for hardware control. An accepted request updates the stored state. The new state is then delivered along one of two routes. The first is a direct write of a three-bit field into a control register, bracketed by a source-request strobe that lasts a fixed dwell time. The second is a start command to an external serial control-word transmitter. Both power-status inputs of the remote domain must be high for the register route to be used.

Requests use a valid/ready handshake. `req_ready` is high only while no transfer is in flight. A request is taken on the clock edge where `req_valid` and `req_ready` are both high, so a requester must hold its request and its fields stable until that edge. Each taken request produces a one-cycle `resp_valid` with a pass/fail flag `resp_ok`. The block cannot stall that response. Rejected requests never make the block busy, so the arbiter acts as a lock that only one transfer can hold at a time.

Top module: `clkbuf_arb`

## Requirements
- R1: After reset, `state_o` is 4'b0001 (buffer 0 on, buffers 1 to 3 off), `req_ready` is 1, and `resp_valid`, `src_req`, `reg_wr_en` and `ser_start` are 0.
- R2: A request with index 4 or higher is rejected. `resp_valid`=1 with `resp_ok`=0 in the cycle after the handshake, `state_o` is unchanged, and neither route starts.
- R3: Each buffer has a 2-bit mode field in `buf_mode[2*i+1:2*i]`. Code 2 means hardware control, and a request to such a buffer is rejected. Every other code (1 = software, and also 0 and 3) lets the request through.
- R4: An accepted request writes `req_on` into bit `req_idx` of `state_o`. The new vector is visible in the cycle after the handshake, together with `resp_valid`=1 and `resp_ok`=1.
- R5: The register route is used when `pwr_pri` and `pwr_sec` are both 1 at the handshake edge. In every other case the serial route is used.
- R6: On the register route, `reg_wr_en` pulses for one cycle, two cycles after the handshake. `reg_wr_data[2:0]` carries state bits 3:1 (bit i-1 holds buffer i). `reg_wr_data[REG_W-1:3]` equals `reg_in[REG_W-1:3]`.
- R7: On the register route, `src_req` rises in the cycle after the handshake and stays high for exactly DWELL_CYC+2 cycles, covering the write. Then it falls and `req_ready` returns to 1.
- R8: On the serial route, `ser_start` is a one-cycle pulse in the cycle after the handshake, with `ser_word` equal to the new state. The block stays busy until `ser_done` is seen high on a clock edge.
- R9: While a transfer is in flight, `req_ready` is 0. Any `req_valid` presented then produces no response and leaves `state_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Arbiter idle, request can be taken |
| req_idx | input | 3 | Target buffer index |
| req_on | input | 1 | Requested on (1) / off (0) |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ok | output | 1 | 1 accepted, 0 rejected |
| buf_mode | input | 8 | Per-buffer mode codes, 2 bits each |
| pwr_pri | input | 1 | Remote domain primary power status |
| pwr_sec | input | 1 | Remote domain secondary power status |
| reg_in | input | 32 | Current control register value |
| src_req | output | 1 | Source-request strobe for the register route |
| reg_wr_en | output | 1 | Control register write strobe |
| reg_wr_data | output | 32 | Value to write into the control register |
| ser_start | output | 1 | Start pulse for the serial transmitter |
| ser_word | output | 4 | State vector handed to the transmitter |
| ser_done | input | 1 | Transmitter finished |
| state_o | output | 4 | Current state vector of all buffers |

## Verification
The response flag, the updated state vector and the first cycle of `src_req` or `ser_start` all appear one cycle after the handshake edge. The register write appears one cycle later. `src_req` then spans DWELL_CYC+2 cycles. The bench drives inputs on the falling edge and samples every output on the following falling edges, stepping exactly one cycle per stage. It counts `src_req` cycle by cycle instead of waiting on it. During the serial wait it presents a competing request and checks that no response appears and the state holds.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_WRITE,
    S_DWELL,
    S_START,
    S_WAIT
  } seq_t;

  localparam logic [1:0] MODE_HW = 2'd2;
endpackage

// File: rtl/clkbuf_gate.sv
module clkbuf_gate #(
  parameter int NBUF  = 4,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [2*NBUF-1:0] mode_cfg,
  output logic              ok
);
  import clkbuf_pkg::*;

  always_comb begin
    ok = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (idx == IDX_W'(i) && mode_cfg[2*i +: 2] != MODE_HW) ok = 1'b1;
    end
  end
endmodule

// File: rtl/clkbuf_state.sv
module clkbuf_state #(
  parameter int              NBUF        = 4,
  parameter int              IDX_W       = 3,
  parameter logic [NBUF-1:0] RESET_STATE = 4'b0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic             on,
  output logic [NBUF-1:0]  state
);
  for (genvar g = 0; g < NBUF; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state[g] <= RESET_STATE[g];
      else if (wr && idx == IDX_W'(g)) state[g] <= on;
    end
  end
endmodule

// File: rtl/clkbuf_seq.sv
module clkbuf_seq #(
  parameter int NBUF      = 4,
  parameter int REG_W     = 32,
  parameter int DWELL_CYC = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             use_reg,
  input  logic [NBUF-1:0]  state,
  input  logic [REG_W-1:0] reg_in,
  input  logic             ser_done,
  output logic             idle,
  output logic             src_req,
  output logic             reg_wr_en,
  output logic [REG_W-1:0] reg_wr_data,
  output logic             ser_start
);
  import clkbuf_pkg::*;

  localparam int FLD_W = NBUF - 1;
  localparam int CNT_W = $clog2(DWELL_CYC + 1);

  seq_t             cur;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (cur)
        S_IDLE:  if (go) cur <= use_reg ? S_REQ : S_START;
        S_REQ:   cur <= S_WRITE;
        S_WRITE: begin
          cur <= S_DWELL;
          cnt <= CNT_W'(DWELL_CYC - 1);
        end
        S_DWELL: begin
          if (cnt == '0) cur <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_START: cur <= S_WAIT;
        S_WAIT:  if (ser_done) cur <= S_IDLE;
        default: cur <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    idle        = (cur == S_IDLE);
    src_req     = (cur == S_REQ) || (cur == S_WRITE) || (cur == S_DWELL);
    reg_wr_en   = (cur == S_WRITE);
    ser_start   = (cur == S_START);
    reg_wr_data = {reg_in[REG_W-1:FLD_W], state[NBUF-1:1]};
  end
endmodule

// File: rtl/clkbuf_arb.sv
module clkbuf_arb #(
  parameter int NBUF      = 4,
  parameter int IDX_W     = 3,
  parameter int REG_W     = 32,
  parameter int DWELL_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              req_on,
  output logic              resp_valid,
  output logic              resp_ok,
  input  logic [2*NBUF-1:0] buf_mode,
  input  logic              pwr_pri,
  input  logic              pwr_sec,
  input  logic [REG_W-1:0]  reg_in,
  output logic              src_req,
  output logic              reg_wr_en,
  output logic [REG_W-1:0]  reg_wr_data,
  output logic              ser_start,
  output logic [NBUF-1:0]   ser_word,
  input  logic              ser_done,
  output logic [NBUF-1:0]   state_o
);
  localparam logic [NBUF-1:0] RST_STATE = NBUF'(1);

  logic take, ok, accept, idle;

  assign take      = req_valid && req_ready;
  assign accept    = take && ok;
  assign req_ready = idle;
  assign ser_word  = state_o;

  clkbuf_gate #(.NBUF(NBUF), .IDX_W(IDX_W)) u_gate (
    .idx(req_idx), .mode_cfg(buf_mode), .ok(ok)
  );

  clkbuf_state #(.NBUF(NBUF), .IDX_W(IDX_W), .RESET_STATE(RST_STATE)) u_state (
    .clk(clk), .rst_n(rst_n), .wr(accept), .idx(req_idx), .on(req_on),
    .state(state_o)
  );

  clkbuf_seq #(.NBUF(NBUF), .REG_W(REG_W), .DWELL_CYC(DWELL_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(accept), .use_reg(pwr_pri && pwr_sec),
    .state(state_o), .reg_in(reg_in), .ser_done(ser_done), .idle(idle),
    .src_req(src_req), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .ser_start(ser_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
    end else begin
      resp_valid <= take;
      resp_ok    <= take && ok;
    end
  end
endmodule

// File: rtl/clkbuf_arb_chk.sv
module clkbuf_arb_chk #(
  parameter int NBUF  = 4,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_ok,
  input logic             src_req,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wr_data,
  input logic [REG_W-1:0] reg_in,
  input logic             ser_start,
  input logic [NBUF-1:0]  state_o
);
  p_reject_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ok |-> $stable(state_o) && !src_req && !ser_start);

  p_accept_routes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ok |-> (src_req ^ ser_start));

  p_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> reg_wr_data[NBUF-2:0] == state_o[NBUF-1:1]
                  && reg_wr_data[REG_W-1:NBUF-1] == reg_in[REG_W-1:NBUF-1]);

  p_write_in_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> src_req && $past(src_req));

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |=> !ser_start);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req || ser_start) |-> !req_ready);
endmodule

bind clkbuf_arb clkbuf_arb_chk #(.NBUF(NBUF), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_ok(resp_ok), .src_req(src_req), .reg_wr_en(reg_wr_en),
  .reg_wr_data(reg_wr_data), .reg_in(reg_in), .ser_start(ser_start),
  .state_o(state_o)
);

// File: tb/clkbuf_arb_bench.sv
module clkbuf_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL      = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_on = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [7:0]  buf_mode = 8'h55;
  logic        pwr_pri = 1'b0, pwr_sec = 1'b0, ser_done = 1'b0;
  logic [31:0] reg_in = '0;
  logic        req_ready, resp_valid, resp_ok, src_req, reg_wr_en, ser_start;
  logic [31:0] reg_wr_data;
  logic [3:0]  ser_word, state_o;
  logic [3:0]  exp_state = 4'b0001;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkbuf_arb #(.DWELL_CYC(DWELL)) u_clkbuf_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_on(req_on), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .buf_mode(buf_mode), .pwr_pri(pwr_pri),
    .pwr_sec(pwr_sec), .reg_in(reg_in), .src_req(src_req),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .ser_start(ser_start), .ser_word(ser_word), .ser_done(ser_done),
    .state_o(state_o)
  );

  function automatic bit exp_ok(input logic [2:0] idx, input logic [7:0] modes);
    if (idx > 3) return 1'b0;
    return modes[2*idx +: 2] != 2'd2;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] rin, input logic [3:0] st);
    return {rin[31:3], st[3], st[2], st[1]};
  endfunction

  task automatic check(input bit cond, input string req, input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] idx, input logic on, input logic pp, input logic ps);
    bit ok;
    int cnt;
    @(negedge clk);
    req_idx = idx; req_on = on; pwr_pri = pp; pwr_sec = ps;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ok = exp_ok(idx, buf_mode);
    if (ok) exp_state[idx[1:0]] = on;
    check(resp_valid == 1'b1, "R4 resp_valid", resp_valid, 1);
    check(resp_ok == ok, ok ? "R4 resp_ok" : "R2/R3 resp_ok", resp_ok, ok);
    check(state_o == exp_state, ok ? "R4 state" : "R2 state", state_o, exp_state);
    if (!ok) begin
      check(!src_req && !ser_start && req_ready, "R2 no route",
            {src_req, ser_start, req_ready}, 3'b001);
    end else if (pp && ps) begin
      check(src_req && !ser_start, "R5 register route", {src_req, ser_start}, 2'b10);
      @(negedge clk);
      check(reg_wr_en == 1'b1, "R6 write strobe", reg_wr_en, 1);
      check(reg_wr_data == exp_word(reg_in, exp_state), "R6 field",
            reg_wr_data, exp_word(reg_in, exp_state));
      cnt = 2;
      for (int k = 0; k < DWELL + 10; k++) begin
        @(negedge clk);
        check(!reg_wr_en, "R6 single write", reg_wr_en, 0);
        if (!src_req) break;
        cnt++;
      end
      check(cnt == DWELL + 2, "R7 dwell length", cnt, DWELL + 2);
      check(req_ready == 1'b1, "R7 ready after dwell", req_ready, 1);
    end else begin
      check(ser_start && !src_req, "R5 serial route", {ser_start, src_req}, 2'b10);
      check(ser_word == exp_state, "R8 ser_word", ser_word, exp_state);
      @(negedge clk);
      check(!ser_start, "R8 start pulse", ser_start, 0);
      req_idx = 3'd0; req_on = ~exp_state[0]; req_valid = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(!req_ready && !resp_valid, "R9 stalled", {req_ready, resp_valid}, 0);
        check(state_o == exp_state, "R9 state held", state_o, exp_state);
      end
      req_valid = 1'b0;
      ser_done = 1'b1;
      @(negedge clk);
      ser_done = 1'b0;
      check(req_ready == 1'b1 && !resp_valid, "R8 done releases", req_ready, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(state_o == 4'b0001, "R1 reset state", state_o, 4'b0001);
    check(req_ready && !resp_valid && !src_req && !reg_wr_en && !ser_start,
          "R1 reset outputs", {req_ready, resp_valid, src_req, reg_wr_en, ser_start}, 5'b10000);
    // directed corners
    buf_mode = 8'b01_01_01_01;
    do_req(3'd5, 1'b1, 1'b1, 1'b1);               // R2 out of range
    do_req(3'd4, 1'b0, 1'b0, 1'b0);               // R2 first invalid index
    buf_mode = 8'b01_10_01_01;
    do_req(3'd2, 1'b1, 1'b1, 1'b1);               // R3 hardware mode
    buf_mode = 8'b11_01_00_01;
    reg_in = 32'hA5A5_A5A5;
    do_req(3'd3, 1'b1, 1'b1, 1'b1);               // R3 code 3 passes, R6
    do_req(3'd1, 1'b1, 1'b1, 1'b0);               // R5 only one power bit
    do_req(3'd0, 1'b0, 1'b0, 1'b1);               // R5 other power bit
    reg_in = 32'hFFFF_FFF8;
    do_req(3'd2, 1'b1, 1'b1, 1'b1);               // R6 all field bits
    // random
    for (int n = 0; n < 40; n++) begin
      buf_mode = 8'($urandom);
      reg_in   = $urandom;
      do_req(3'($urandom), 1'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule